// File: doc/BRIEF.md
# Backup Cell Selection and Isolation Controller

This block is the digital decision logic behind a battery-backed memory supply rail. It watches five comparator flags: main supply above the battery voltage, main supply below the power-fail threshold, primary cell above its 2.5 V health level, a cell-connected event, and a flag saying that chip-enable sits in the mid-level band. From these it drives four select outputs that close exactly one analog switch: main supply, cell 1, cell 2, or none (isolated, both cells disconnected).

While the supply is above the battery voltage the rail runs from the main supply. In backup, cell 1 is used while it is healthy and cell 2 otherwise. To keep fresh cells from draining, an isolation latch disconnects both cells. It is set when a battery is first connected. It is also set by a deliberate request: chip-enable held at mid-level for a minimum number of clock cycles while the supply falls between the fail threshold and the switch-over level. The latch is released after the main supply has been applied and then removed again. Each change of source opens all switches for one clock cycle first, so two sources are never joined.

Top module: `nvBackupSel`

## Requirements
- R1: While reset is asserted all four select outputs are low.
- R2: When the supply-above-battery flag is high, the main select is the one that ends up high, including on power-up from backup.
- R3: In backup (supply-above-battery low, not isolated) with the cell 1 health flag high, the cell 1 select is high.
- R4: In backup with the cell 1 health flag low, the cell 2 select is high; health changes move the rail between the cells.
- R5: At most one select is high at any time. A change of source shows exactly one cycle with all selects low, and the new select is high in the following cycle.
- R6: A one-cycle cell-attach pulse sets the isolation latch: in backup the isolated select becomes high, whatever the cell health flag says; with the supply up the main select stays high.
- R7: If the mid-level flag is high for at least MIN_PULSE_CYC consecutive sampled cycles inside the window (below-fail high and above-battery high), and the window then closes by above-battery going low, the block enters the isolated state.
- R8: A mid-level run one cycle shorter than MIN_PULSE_CYC does not isolate; the proper cell is selected.
- R9: A low mid-level flag at any point inside the window cancels the request for the rest of that window, even if the flag is later held for longer than MIN_PULSE_CYC.
- R10: Once isolated, the latch is released after the supply is applied (main selected) and then removed; the cell chosen by the health flag is then selected.
- R11: A window that closes because the supply recovers (below-fail low) discards any pending request, and its counter starts again from zero in the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supplyAboveBat | input | 1 | Main supply above the active battery voltage |
| supplyBelowFail | input | 1 | Main supply below the power-fail threshold |
| cell1Good | input | 1 | Cell 1 above 2.5 V |
| cellAttach | input | 1 | One-cycle pulse when a battery is first connected |
| ceMidLevel | input | 1 | Chip-enable inside the mid-level band |
| selMain | output | 1 | Connect the main supply to the rail |
| selCell1 | output | 1 | Connect cell 1 to the rail |
| selCell2 | output | 1 | Connect cell 2 to the rail |
| selIsolated | output | 1 | Both cells isolated, rail unpowered |

## Verification
A flag change sampled at rising edge k shows as all selects low after edge k, and the new select is high after edge k+1. A cell-attach pulse acts one edge later, because the latch it sets is seen only at the next edge, so its all-low cycle follows edge k+1. A mid-level run counts only the rising edges at which both the flag and the window are high. The bench drives every input at the falling edge and counts the rising edges before it samples at a later falling edge, so each check lands on the cycle in which the value is due.

// File: rtl/nvBackupPkg.sv
package nvBackupPkg;

  typedef enum logic [2:0] {
    SRC_OFF   = 3'd0,
    SRC_MAIN  = 3'd1,
    SRC_CELL1 = 3'd2,
    SRC_CELL2 = 3'd3,
    SRC_ISO   = 3'd4
  } srcSel_e;

  // Strobes from the isolation control to the switch datapath
  typedef struct packed {
    logic useMain;
    logic isolate;
    logic preferCell1;
  } srcReq_t;

endpackage

// File: rtl/nvIsoCtrl.sv
module nvIsoCtrl
  import nvBackupPkg::*;
#(
  parameter int MIN_PULSE_CYC = 175
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    supplyAboveBat,
  input  logic    supplyBelowFail,
  input  logic    cell1Good,
  input  logic    cellAttach,
  input  logic    ceMidLevel,
  output srcReq_t req
);

  localparam int CNT_W = $clog2(MIN_PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_PULSE_CYC);

  logic [CNT_W-1:0] midCnt;
  logic armed, spoiled, windowPrev, isoLatch, seenPower;
  logic inWindow, closeDown, setIso, clrIso;

  // Window: supply between the fail threshold and the switch-over level
  assign inWindow  = supplyBelowFail & supplyAboveBat;
  assign closeDown = windowPrev & ~supplyAboveBat;
  assign setIso    = cellAttach | (closeDown & armed);
  assign clrIso    = isoLatch & seenPower & ~supplyAboveBat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      midCnt     <= '0;
      armed      <= 1'b0;
      spoiled    <= 1'b0;
      windowPrev <= 1'b0;
    end else begin
      windowPrev <= inWindow;
      if (!inWindow) begin
        midCnt  <= '0;
        armed   <= 1'b0;
        spoiled <= 1'b0;
      end else if (!ceMidLevel) begin
        midCnt  <= '0;
        armed   <= 1'b0;
        spoiled <= 1'b1;
      end else if (!spoiled && midCnt != CNT_SAT) begin
        midCnt <= midCnt + 1'b1;
        if (midCnt == CNT_LAST) armed <= 1'b1;
      end
    end
  end

  // Isolation latch: set has priority over release
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isoLatch  <= 1'b0;
      seenPower <= 1'b0;
    end else if (setIso) begin
      isoLatch  <= 1'b1;
      seenPower <= 1'b0;
    end else if (clrIso) begin
      isoLatch  <= 1'b0;
      seenPower <= 1'b0;
    end else if (isoLatch && supplyAboveBat) begin
      seenPower <= 1'b1;
    end
  end

  assign req.useMain     = supplyAboveBat;
  assign req.isolate     = isoLatch;
  assign req.preferCell1 = cell1Good;

endmodule

// File: rtl/nvSrcSwitch.sv
module nvSrcSwitch
  import nvBackupPkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  srcReq_t req,
  output logic    selMain,
  output logic    selCell1,
  output logic    selCell2,
  output logic    selIsolated
);

  srcSel_e target, cur;

  always_comb begin
    if (req.useMain)          target = SRC_MAIN;
    else if (req.isolate)     target = SRC_ISO;
    else if (req.preferCell1) target = SRC_CELL1;
    else                      target = SRC_CELL2;
  end

  // Break before make: any change passes through SRC_OFF for one cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                cur <= SRC_OFF;
    else if (cur == SRC_OFF)   cur <= target;
    else if (cur != target)    cur <= SRC_OFF;
  end

  always_comb begin
    selMain     = 1'b0;
    selCell1    = 1'b0;
    selCell2    = 1'b0;
    selIsolated = 1'b0;
    case (cur)
      SRC_MAIN:  selMain     = 1'b1;
      SRC_CELL1: selCell1    = 1'b1;
      SRC_CELL2: selCell2    = 1'b1;
      SRC_ISO:   selIsolated = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/nvBackupSel.sv
module nvBackupSel
  import nvBackupPkg::*;
#(
  parameter int MIN_PULSE_CYC = 175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supplyAboveBat,
  input  logic supplyBelowFail,
  input  logic cell1Good,
  input  logic cellAttach,
  input  logic ceMidLevel,
  output logic selMain,
  output logic selCell1,
  output logic selCell2,
  output logic selIsolated
);

  srcReq_t req;

  nvIsoCtrl #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .supplyAboveBat  (supplyAboveBat),
    .supplyBelowFail (supplyBelowFail),
    .cell1Good       (cell1Good),
    .cellAttach      (cellAttach),
    .ceMidLevel      (ceMidLevel),
    .req             (req)
  );

  nvSrcSwitch u_sw (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .selMain     (selMain),
    .selCell1    (selCell1),
    .selCell2    (selCell2),
    .selIsolated (selIsolated)
  );

endmodule

// File: rtl/nvBackupSel_chk.sv
module nvBackupSel_chk (
  input logic clk,
  input logic rst_n,
  input logic supplyAboveBat,
  input logic cell1Good,
  input logic cellAttach,
  input logic selMain,
  input logic selCell1,
  input logic selCell2,
  input logic selIsolated
);

  logic [3:0] selVec;
  assign selVec = {selMain, selCell1, selCell2, selIsolated};

  // R1
  always_comb begin
    if (!rst_n) a_r1_reset_off : assert (selVec == 4'b0000);
  end

  a_r5_one_source : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(selVec));

  a_r5_break_first : assert property (@(posedge clk) disable iff (!rst_n)
    (|selVec) |=> ((selVec == $past(selVec)) || (selVec == 4'b0000)));

  a_r2_cells_only_in_backup : assert property (@(posedge clk) disable iff (!rst_n)
    (selCell1 || selCell2 || selIsolated) |-> !$past(supplyAboveBat));

  a_r3_cell1_healthy : assert property (@(posedge clk) disable iff (!rst_n)
    selCell1 |-> $past(cell1Good));

  a_r4_cell2_weak : assert property (@(posedge clk) disable iff (!rst_n)
    selCell2 |-> !$past(cell1Good));

  a_r6_attach_isolates : assert property (@(posedge clk) disable iff (!rst_n)
    cellAttach |=> ##1 !(selCell1 || selCell2));

endmodule

bind nvBackupSel nvBackupSel_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .supplyAboveBat (supplyAboveBat),
  .cell1Good      (cell1Good),
  .cellAttach     (cellAttach),
  .selMain        (selMain),
  .selCell1       (selCell1),
  .selCell2       (selCell2),
  .selIsolated    (selIsolated)
);

// File: tb/tb_nvBackupSel.sv
module tb_nvBackupSel;

  localparam int MINP = 175;
  localparam logic [3:0] S_OFF = 4'b0000, S_MAIN = 4'b1000, S_C1 = 4'b0100,
                         S_C2 = 4'b0010, S_ISO = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supplyAboveBat = 1'b1, supplyBelowFail = 1'b0, cell1Good = 1'b1;
  logic cellAttach = 1'b0, ceMidLevel = 1'b0;
  logic selMain, selCell1, selCell2, selIsolated;
  logic [3:0] sels;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign sels = {selMain, selCell1, selCell2, selIsolated};

  always #2 clk = ~clk;

  nvBackupSel #(.MIN_PULSE_CYC(MINP)) dut (
    .clk(clk), .rst_n(rst_n), .supplyAboveBat(supplyAboveBat),
    .supplyBelowFail(supplyBelowFail), .cell1Good(cell1Good),
    .cellAttach(cellAttach), .ceMidLevel(ceMidLevel),
    .selMain(selMain), .selCell1(selCell1), .selCell2(selCell2),
    .selIsolated(selIsolated)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] exp);
    checks++;
    if (sels !== exp) begin
      errors++;
      $display("FAIL %s: sels=%b expected=%b at %0t", tag, sels, exp, $time);
    end
  endtask

  // Inputs change now; expect break cycle then the new source
  task automatic expectSwitch(input string tag, input logic [3:0] exp);
    step(1); check({tag, " break"}, S_OFF);
    step(1); check(tag, exp);
  endtask

  task automatic powerUp(input string tag);
    supplyAboveBat = 1'b1; supplyBelowFail = 1'b0; ceMidLevel = 1'b0;
    expectSwitch(tag, S_MAIN);
  endtask

  task automatic powerDown(input string tag, input logic [3:0] exp);
    supplyBelowFail = 1'b1; supplyAboveBat = 1'b0; ceMidLevel = 1'b0;
    expectSwitch(tag, exp);
  endtask

  task automatic t_reset();
    step(3); check("R1 during reset", S_OFF);
    rst_n = 1'b1;
    step(1); check("R2 main after reset", S_MAIN);
    step(5); check("R2 main holds", S_MAIN);
  endtask

  task automatic t_cellChoice();
    cell1Good = 1'b1;
    powerDown("R3 backup cell1", S_C1);
    cell1Good = 1'b0; expectSwitch("R4 cell1 weak -> cell2", S_C2);
    step(4); check("R4 cell2 holds", S_C2);
    cell1Good = 1'b1; expectSwitch("R4 cell1 recovers", S_C1);
    powerUp("R2 power-up to main");
  endtask

  task automatic t_attach();
    cell1Good = 1'b1;
    powerDown("R3 before attach", S_C1);
    cellAttach = 1'b1; step(1); cellAttach = 1'b0;
    check("R6 attach latency", S_C1);
    step(1); check("R6 break", S_OFF);
    step(1); check("R6 isolated", S_ISO);
    cell1Good = 1'b0; step(3); check("R6 health ignored", S_ISO);
    powerUp("R10 main while applied");
    powerDown("R10 reconnect cell2", S_C2);
    cell1Good = 1'b1; expectSwitch("R4 back to cell1", S_C1);
    powerUp("R2 up again");
    cellAttach = 1'b1; step(1); cellAttach = 1'b0;
    step(3); check("R6 attach with supply up", S_MAIN);
    powerDown("R10 release after attach when up", S_C1);
    powerUp("R2 up after release");
  endtask

  task automatic t_ceRequest(input string tag, input int n, input logic [3:0] exp);
    cell1Good = 1'b1;
    supplyBelowFail = 1'b1; ceMidLevel = 1'b1;
    step(n); check({tag, " main in window"}, S_MAIN);
    supplyAboveBat = 1'b0;
    expectSwitch(tag, exp);
    powerUp({tag, " restore"});
    if (exp == S_ISO) begin
      powerDown("R10 released after cycle", S_C1);
      powerUp("R10 up");
    end
  endtask

  task automatic t_cancel();
    supplyBelowFail = 1'b1; ceMidLevel = 1'b1; step(10);
    ceMidLevel = 1'b0; step(1);
    ceMidLevel = 1'b1; step(MINP + 5);
    supplyAboveBat = 1'b0;
    expectSwitch("R9 cancelled request", S_C1);
    powerUp("R9 restore");
  endtask

  task automatic t_recover();
    supplyBelowFail = 1'b1; ceMidLevel = 1'b1; step(MINP + 5);
    supplyBelowFail = 1'b0; step(2); check("R11 recovery keeps main", S_MAIN);
    supplyBelowFail = 1'b1; step(3);
    supplyAboveBat = 1'b0;
    expectSwitch("R11 request discarded", S_C1);
    powerUp("R11 restore");
  endtask

  initial begin
    t_reset();
    t_cellChoice();
    t_attach();
    t_ceRequest("R7 full pulse", MINP, S_ISO);
    t_ceRequest("R8 short pulse", MINP - 1, S_C1);
    t_cancel();
    t_recover();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule